// File: doc/BRIEF.md
# LIN Header Transmitter with Bit-Error Monitor

This block sends the header part of a LIN frame on a single serial output line. The line is paced by a sample tick, and each bit time spans a fixed number of ticks. Software starts a header with a one-cycle start pulse. The header always opens with a low break of programmable length. A one-bit high delimiter follows the break. After that, and only if selected, come a sync byte and a protected identifier byte. The identifier's two parity bits are computed in hardware from a six-bit ID.

While a header is being sent, the block watches the bus input that is looped back from the line. It compares that input with the value it drives, once per bit, at the middle of the bit. When checking is enabled, any difference raises a sticky bit-error flag. At the end of the header the busy indication drops and a done flag is raised. Both flags are write-1-to-clear. An interrupt request is raised while either flag is set and the interrupt enable is on.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, and whenever no header is in progress, `line_out` is high and `busy` is low. After reset, `done_flag`, `berr_flag` and `irq` are low.
- R2: Every bit lasts OVS sample ticks. The break is `brk_extra + 8` consecutive low bits, followed by exactly one high delimiter bit.
- R3: `hdr_sel` chooses what follows the delimiter. 2'b00 sends nothing more. 2'b01 sends the sync frame. 2'b10 sends the sync frame and then the identifier frame. 2'b11 behaves exactly like 2'b00.
- R4: The sync frame is a low start bit, then the byte 0x55 sent least significant bit first, then a high stop bit.
- R5: The identifier frame has the same framing as the sync frame and carries the byte {P1, P0, id[5:0]}. P0 = id0^id1^id2^id4 and P1 = ~(id1^id3^id4^id5).
- R6: `busy` rises on the cycle after an accepted start pulse. On the clock edge that ends the last bit, `busy` falls and `done_flag` rises.
- R7: A start pulse that arrives while `busy` is high is ignored. The header in progress continues unchanged and no second header follows it.
- R8: `clr_done` clears `done_flag` and `clr_berr` clears `berr_flag`. If a flag is set and cleared in the same cycle, the set wins.
- R9: When `berr_en` is high, `berr_flag` is set if `line_in` differs from `line_out` at the mid-bit sample. The mid-bit sample is the tick taken at phase OVS/2 of the bit. When `berr_en` is low, a mismatch leaves `berr_flag` unchanged.
- R10: `irq` is high exactly when `irq_en` is high and at least one of `done_flag` or `berr_flag` is set.
- R11: `brk_extra`, `hdr_sel` and `id` are captured when a start is accepted. Changing them during a header has no effect on that header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Sample-rate enable; OVS ticks per bit |
| start_wr | input | 1 | One-cycle pulse that starts a header |
| brk_extra | input | BRK_W | Extra break bits beyond eight |
| hdr_sel | input | 2 | Header content select |
| id | input | 6 | Identifier bits used to build the protected identifier |
| berr_en | input | 1 | Bit-error check enable |
| irq_en | input | 1 | Interrupt enable |
| clr_done | input | 1 | Write-1 clear of the done flag |
| clr_berr | input | 1 | Write-1 clear of the bit-error flag |
| line_in | input | 1 | Bus level read back from the line |
| line_out | output | 1 | Serial output line |
| busy | output | 1 | High while a header is in progress |
| done_flag | output | 1 | Header-sent flag |
| berr_flag | output | 1 | Bit-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with OVS = 4 and BRK_W = 3. With these values the longest header is about 36 bits, so a full header takes a few hundred clocks. This lets the bench cover both break-length extremes and every `hdr_sel` code. It also injects mismatches on the readback line, once with checking enabled and once with it disabled. It changes the configuration and pulses start again partway through a header to confirm that both are ignored. The bench compares the line at the middle of every bit against a list of bits it computes itself, and then confirms that no bit is missing or extra.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_DELIM,
    ST_SYNC,
    ST_PID
  } lin_st_e;

  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam int FRAME_BITS = 10;

  // Protected identifier: parity bits on top of the 6-bit ID.
  function automatic logic [7:0] lin_pid_calc(input logic [5:0] id);
    logic p0;
    logic p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  // Bit of a start/8-data/stop frame: 0 = start, 1..8 = data LSB first, 9 = stop.
  function automatic logic frame_bit(input logic [7:0] data, input logic [3:0] idx);
    if (idx == 4'd0)      return 1'b0;
    else if (idx >= 4'd9) return 1'b1;
    else                  return data[idx - 4'd1];
  endfunction

endpackage

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_end,
  output logic mid_pt
);
  localparam int PW  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int MID = OVS / 2;

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= '0;
    else if (!run)           phase <= '0;
    else if (tick) begin
      if (phase == PW'(OVS - 1)) phase <= '0;
      else                       phase <= phase + 1'b1;
    end
  end

  assign bit_end = run && tick && (phase == PW'(OVS - 1));
  assign mid_pt  = run && tick && (phase == PW'(MID));

  // R2
  phase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> phase == '0);

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int BRK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic [BRK_W-1:0] brk_extra,
  input  logic [1:0]       hdr_sel,
  input  logic [5:0]       id,
  input  logic             bit_end,
  output logic             busy,
  output logic             tx_bit,
  output logic             hdr_end
);
  localparam int CW = BRK_W + 4;

  lin_st_e        st;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  brk_len;
  logic [1:0]     sel_q;
  logic [7:0]     pid_q;
  logic           wants_sync;
  logic           wants_pid;
  logic           frame_last;
  logic           last_bit;

  assign wants_sync = (sel_q == 2'b01) || (sel_q == 2'b10);
  assign wants_pid  = (sel_q == 2'b10);
  assign frame_last = (cnt == CW'(FRAME_BITS - 1));
  assign busy       = (st != ST_IDLE);

  always_comb begin
    case (st)
      ST_DELIM: last_bit = !wants_sync;
      ST_SYNC:  last_bit = frame_last && !wants_pid;
      ST_PID:   last_bit = frame_last;
      default:  last_bit = 1'b0;
    endcase
  end

  assign hdr_end = bit_end && last_bit;

  always_comb begin
    case (st)
      ST_BRK:  tx_bit = 1'b0;
      ST_SYNC: tx_bit = frame_bit(SYNC_BYTE, cnt[3:0]);
      ST_PID:  tx_bit = frame_bit(pid_q, cnt[3:0]);
      default: tx_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      brk_len <= '0;
      sel_q   <= '0;
      pid_q   <= '0;
    end else if (st == ST_IDLE) begin
      if (start_go) begin
        st      <= ST_BRK;
        cnt     <= '0;
        brk_len <= CW'(brk_extra) + CW'(8);
        sel_q   <= hdr_sel;
        pid_q   <= lin_pid_calc(id);
      end
    end else if (bit_end) begin
      case (st)
        ST_BRK: begin
          if (cnt == brk_len - 1'b1) begin
            st  <= ST_DELIM;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DELIM: begin
          st  <= wants_sync ? ST_SYNC : ST_IDLE;
          cnt <= '0;
        end
        ST_SYNC: begin
          if (frame_last) begin
            st  <= wants_pid ? ST_PID : ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PID: begin
          if (frame_last) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  brk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BRK) |-> (cnt < brk_len));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pid_q) && $stable(sel_q));

endmodule

// File: rtl/lin_bit_check.sv
module lin_bit_check (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_en,
  input  logic busy,
  input  logic mid_pt,
  input  logic tx_bit,
  input  logic line_in,
  input  logic clr,
  output logic flag
);
  logic mismatch;

  assign mismatch = chk_en && mid_pt && (line_in != tx_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (mismatch) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  // R9
  mid_in_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_pt |-> busy);

  // R9
  berr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(chk_en) && $past(busy));

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
  parameter int OVS   = 16,
  parameter int BRK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             start_wr,
  input  logic [BRK_W-1:0] brk_extra,
  input  logic [1:0]       hdr_sel,
  input  logic [5:0]       id,
  input  logic             berr_en,
  input  logic             irq_en,
  input  logic             clr_done,
  input  logic             clr_berr,
  input  logic             line_in,
  output logic             line_out,
  output logic             busy,
  output logic             done_flag,
  output logic             berr_flag,
  output logic             irq
);
  logic start_go;
  logic bit_end;
  logic mid_pt;
  logic hdr_end;
  logic tx_bit;

  assign start_go = start_wr && !busy;

  lin_bit_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(sample_tick),
    .bit_end(bit_end), .mid_pt(mid_pt)
  );

  lin_hdr_seq #(.BRK_W(BRK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .brk_extra(brk_extra),
    .hdr_sel(hdr_sel), .id(id), .bit_end(bit_end),
    .busy(busy), .tx_bit(tx_bit), .hdr_end(hdr_end)
  );

  lin_bit_check u_chk (
    .clk(clk), .rst_n(rst_n), .chk_en(berr_en), .busy(busy), .mid_pt(mid_pt),
    .tx_bit(tx_bit), .line_in(line_in), .clr(clr_berr), .flag(berr_flag)
  );

  assign line_out = tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (hdr_end)  done_flag <= 1'b1;
    else if (clr_done) done_flag <= 1'b0;
  end

  assign irq = irq_en && (done_flag || berr_flag);

  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy));

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out);

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_wr && !hdr_end) |=> busy);

endmodule

// File: tb/lin_hdr_tx_tb.sv
module lin_hdr_tx_tb;
  localparam int OVS   = 4;
  localparam int BRK_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic start_wr = 1'b0;
  logic [BRK_W-1:0] brk_extra = '0;
  logic [1:0] hdr_sel = 2'b00;
  logic [5:0] id = '0;
  logic berr_en = 1'b0;
  logic irq_en = 1'b0;
  logic clr_done = 1'b0;
  logic clr_berr = 1'b0;
  logic inject = 1'b0;
  logic line_in;
  logic line_out, busy, done_flag, berr_flag, irq;

  int total = 0;
  int bad = 0;
  logic exp_q[$];
  int tick_idx = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign line_in = line_out ^ inject;

  lin_hdr_tx #(.OVS(OVS), .BRK_W(BRK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .start_wr(start_wr),
    .brk_extra(brk_extra), .hdr_sel(hdr_sel), .id(id), .berr_en(berr_en),
    .irq_en(irq_en), .clr_done(clr_done), .clr_berr(clr_berr),
    .line_in(line_in), .line_out(line_out), .busy(busy),
    .done_flag(done_flag), .berr_flag(berr_flag), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Parity restated as masked reductions.
  function automatic logic [7:0] pid_ref(input logic [5:0] v);
    logic a, b;
    a = ^(v & 6'b010111);
    b = ~^(v & 6'b111010);
    return {b, a, v};
  endfunction

  task automatic push_frame(input logic [7:0] d);
    exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
    exp_q.push_back(1'b1);
  endtask

  // Tick generator and monitor: one tick every two clocks; at each tick
  // inside a header, the mid phase bit is compared with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (busy && sample_tick) begin
        if (tick_idx % OVS == OVS / 2) begin
          if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R3 extra bit actual=%0b expected=none", line_out);
          end else begin
            logic e;
            e = exp_q.pop_front();
            check("R2/R4/R5 line bit", line_out, e);
          end
        end
        tick_idx++;
      end
      if (!busy) tick_idx = 0;
      sample_tick = ~sample_tick;
    end
  end

  task automatic send_hdr(input logic [BRK_W-1:0] ex, input logic [1:0] sel,
                          input logic [5:0] idv);
    int guard;
    for (int i = 0; i < int'(ex) + 8; i++) exp_q.push_back(1'b0);
    exp_q.push_back(1'b1);
    if (sel == 2'b01 || sel == 2'b10) push_frame(8'h55);
    if (sel == 2'b10) push_frame(pid_ref(idv));
    @(negedge clk);
    brk_extra = ex; hdr_sel = sel; id = idv; start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    check("R6 busy after start", busy, 1'b1);
  endtask

  task automatic wait_end();
    int guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    check("R6 done with busy fall", done_flag, 1'b1);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3 missing bits actual=%0d expected=0", exp_q.size());
      exp_q.delete();
    end
    check("R1 idle line high", line_out, 1'b1);
  endtask

  task automatic pulse_clr_done();
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset line", line_out, 1'b1);
    check("R1 reset busy", busy, 1'b0);
    check("R1 reset done", done_flag, 1'b0);
    check("R1 reset berr", berr_flag, 1'b0);
    check("R1 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 shortest break, break only
    send_hdr(3'd0, 2'b00, 6'h00); wait_end();
    check("R10 irq off when disabled", irq, 1'b0);
    irq_en = 1'b1; #1;
    check("R10 irq on with done", irq, 1'b1);
    pulse_clr_done();
    check("R8 done cleared", done_flag, 1'b0);
    check("R10 irq off after clear", irq, 1'b0);

    // R2 longest break with sync, R4
    send_hdr(3'd7, 2'b01, 6'h00); wait_end(); pulse_clr_done();

    // R5 full headers with several IDs
    send_hdr(3'd2, 2'b10, 6'h3C); wait_end(); pulse_clr_done();
    send_hdr(3'd5, 2'b10, 6'h01); wait_end(); pulse_clr_done();
    send_hdr(3'd1, 2'b10, 6'h3F); wait_end(); pulse_clr_done();

    // R3 reserved code acts as break only
    send_hdr(3'd3, 2'b11, 6'h2A); wait_end(); pulse_clr_done();

    // R7 and R11: restart and config change mid-header are ignored
    send_hdr(3'd1, 2'b10, 6'h12);
    repeat (60) @(negedge clk);
    hdr_sel = 2'b00; id = 6'h3F; brk_extra = 3'd7; start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    wait_end();
    repeat (10) @(negedge clk);
    check("R7 no second header", busy, 1'b0);
    pulse_clr_done();

    // R9 disabled check ignores mismatch
    berr_en = 1'b0;
    send_hdr(3'd0, 2'b01, 6'h00);
    inject = 1'b1; wait_end(); inject = 1'b0;
    check("R9 no flag when disabled", berr_flag, 1'b0);
    pulse_clr_done();
    check("R10 irq low with no flags", irq, 1'b0);

    // R9 enabled check flags mismatch
    berr_en = 1'b1;
    send_hdr(3'd0, 2'b01, 6'h00);
    repeat (20) @(negedge clk);
    inject = 1'b1; repeat (20) @(negedge clk); inject = 1'b0;
    wait_end();
    check("R9 flag on mismatch", berr_flag, 1'b1);
    pulse_clr_done();
    check("R10 irq from berr", irq, 1'b1);
    @(negedge clk); clr_berr = 1'b1; @(negedge clk); clr_berr = 1'b0;
    check("R8 berr cleared", berr_flag, 1'b0);

    // R8 set wins over clear on the final edge
    send_hdr(3'd0, 2'b00, 6'h00);
    clr_done = 1'b1;
    wait_end();
    clr_done = 1'b0;
    check("R8 set beats clear", done_flag, 1'b1);
    pulse_clr_done();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule